// File: doc/BRIEF.md
# SPI Configuration Loader for an FPGA Slave Port

This block is an SPI master sequencer that configures a downstream FPGA through its slave SPI configuration port. When `start` is pulsed, it latches the image length and runs a fixed script. It reads the target's identity word and checks it against two accepted values. It then reads status once and issues refresh, write-enable and erase commands. Next it polls status until the erase is reported complete, with a tick-timed pause between polls and a bounded number of attempts. It then sends the whole image as one chip-select frame, issues write-disable, and reads status a final time to see whether the target reports configuration complete.

Image bytes come from a valid/ready byte stream with a last flag. A millisecond tick input times the pause between status polls. At the end of the run the block raises a sticky `done` flag together with a result code. The SPI link runs in mode 0, most significant bit first. The serial clock is a parameterized division of the system clock.

Top module: `spi_cfg_loader`

## Requirements
- R1: A start with `img_len` equal to 0 sets `done` with result code 1 (empty image) on the clock edge that samples `start`, and no chip-select frame is issued.
- R2: The first frame is 8 bytes: opcode 0x07, three 0x00 bytes, then four 0x00 bytes during which the identity is received; the identity is the big-endian word of received bytes 4..7.
- R3: The run continues only for identity 0xC2088080 or 0xC2048080; any other identity ends the run with result code 2 (bad identity) after that single frame.
- R4: After an accepted identity, one 8-byte status read (opcode 0x09, same layout and byte order as R2) is made, followed by three 4-byte frames in this order: 0x71, 0x4A, 0x70, each opcode followed by three 0x00 bytes.
- R5: After the 0x70 frame, status reads repeat until a read returns exactly 0x00010000 (any other value, even with that bit set, counts as not cleared); between two consecutive polls the block waits `POLL_TICKS` ticks of `ms_tick`.
- R6: If `MAX_POLLS` consecutive polls fail, the run ends with result code 3 (erase timeout) and no image frame is sent.
- R7: The image goes out in one frame: 0x41, three 0xFF bytes, the image bytes in stream order, then four 0x00 bytes.
- R8: The image body ends after `img_len` bytes, or earlier at the first byte accepted with `s_last` high; bytes beyond that are not taken.
- R9: `s_ready` is high only inside a frame while the block waits for the next image byte, and each accepted byte is sent exactly once.
- R10: After the image frame, a 4-byte frame 0x4F with three 0x00 bytes is sent, then one status read; the result is 0 (success) if status bit mask 0x00004000 is set, otherwise 4 (not configured).
- R11: SPI mode 0, MSB first: `sclk` idles low and is low whenever `cs_n` is high, `cs_n` stays low for a whole frame, and it is high for at least one `sclk` period between frames.
- R12: `busy` is high from the accepted start to the end of the run; `done` and `err` then hold until the next start, and a `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| img_len | input | LEN_W | Image length in bytes, sampled at start |
| s_data | input | 8 | Image stream byte |
| s_valid | input | 1 | Image stream byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block takes the image byte this cycle |
| ms_tick | input | 1 | One-cycle millisecond tick |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the target |
| miso | input | 1 | SPI data from the target |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| err | output | 3 | Result code: 0 ok, 1 empty, 2 bad identity, 3 erase timeout, 4 not configured |

## Verification
The bench models the target as a bit-level SPI slave. It decodes every frame and returns identity and status words that change with the script's progress. A swapped byte order or a bit taken on the wrong edge therefore shows up as a rejected identity or a wrong result code. One identity differs from an accepted value by a single bit. One erase status has the cleared bit set plus one more bit, which exposes a design that masks where it should compare. Separate runs end the image body at the length and, earlier, at the last flag, with stream stalls in one of them, so an off-by-one body count or a byte taken twice shows up as a wrong frame length or a wrong byte. A run that never clears must stop after exactly the poll limit with no image frame. A start pulse in the middle of a run must leave the outcome unchanged.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        RES_OK       = 3'd0,
        RES_EMPTY    = 3'd1,
        RES_BAD_ID   = 3'd2,
        RES_ERASE_TO = 3'd3,
        RES_NOT_CFG  = 3'd4
    } result_e;

    typedef enum logic [3:0] {
        STEP_IDENT, STEP_STAT0, STEP_REFRESH, STEP_WREN, STEP_ERASE,
        STEP_POLL, STEP_IMAGE, STEP_WRDIS, STEP_STATF
    } step_e;

    typedef enum logic [1:0] {SEG_HEAD, SEG_BODY, SEG_TAIL} seg_e;

    typedef enum logic [2:0] {PH_IDLE, PH_FRAME, PH_GAP, PH_DECIDE, PH_WAIT} phase_e;

    localparam logic [31:0] IDENT_A      = 32'hC208_8080;
    localparam logic [31:0] IDENT_B      = 32'hC204_8080;
    localparam logic [31:0] STAT_ERASED  = 32'h0001_0000;
    localparam logic [31:0] STAT_CFG_BIT = 32'h0000_4000;

    function automatic logic [7:0] step_opcode(step_e s);
        case (s)
            STEP_IDENT:   return 8'h07;
            STEP_REFRESH: return 8'h71;
            STEP_WREN:    return 8'h4A;
            STEP_ERASE:   return 8'h70;
            STEP_IMAGE:   return 8'h41;
            STEP_WRDIS:   return 8'h4F;
            default:      return 8'h09;
        endcase
    endfunction

    function automatic logic step_reads(step_e s);
        return (s == STEP_IDENT) || (s == STEP_STAT0) || (s == STEP_POLL) || (s == STEP_STATF);
    endfunction

    function automatic logic ident_ok(logic [31:0] w);
        return (w == IDENT_A) || (w == IDENT_B);
    endfunction

endpackage

// File: rtl/cfgld_spi_byte.sv
module cfgld_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       miso,
    output logic       done,
    output logic [7:0] dout,
    output logic       sclk,
    output logic       mosi
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q, rx_q;
    logic          run_q, sclk_q, done_q;
    logic          half_end;

    assign half_end = (div_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
            run_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (load) begin
                    run_q <= 1'b1; tx_q <= din;
                    div_q <= '0; bit_q <= '0; sclk_q <= 1'b0;
                end
            end else if (half_end) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    assign done = done_q;
    assign dout = rx_q;
    assign sclk = sclk_q;
    assign mosi = tx_q[7];
endmodule

// File: rtl/cfgld_tick_wait.sv
module cfgld_tick_wait #(
    parameter int COUNT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tick,
    output logic expired
);
    localparam int TW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [TW-1:0] cnt_q;
    logic          run_q, exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0; run_q <= 1'b0; exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (arm) begin
                cnt_q <= '0; run_q <= 1'b1;
            end else if (run_q && tick) begin
                if (cnt_q == TW'(COUNT - 1)) begin
                    run_q <= 1'b0; exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + TW'(1);
                end
            end
        end
    end

    assign expired = exp_q;
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int HALF_DIV   = 2,
    parameter int POLL_TICKS = 10,
    parameter int MAX_POLLS  = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    input  logic             ms_tick,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [2:0]       err
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int PW      = $clog2(MAX_POLLS + 1);

    phase_e           phase_q;
    step_e            step_q, nxt_step;
    seg_e             seg_q;
    result_e          res_q, fin_code;
    logic [1:0]       hidx_q;
    logic [LEN_W-1:0] len_q, body_cnt_q;
    logic             body_end_q, inflight_q, cs_q, done_q;
    logic [31:0]      word_q;
    logic [PW-1:0]    poll_q;
    logic [GW-1:0]    gap_q;
    logic [7:0]       cur_byte, sh_dout;
    logic             sh_load, sh_done, wait_exp;
    logic             go_frame, go_wait, go_fin;

    // byte to send next, by segment of the frame
    always_comb begin
        case (seg_q)
            SEG_HEAD: cur_byte = (hidx_q == 2'd0) ? step_opcode(step_q)
                               : ((step_q == STEP_IMAGE) ? 8'hFF : 8'h00);
            SEG_BODY: cur_byte = s_data;
            default:  cur_byte = 8'h00;
        endcase
    end

    assign s_ready = (phase_q == PH_FRAME) && !inflight_q && (seg_q == SEG_BODY);
    assign sh_load = (phase_q == PH_FRAME) && !inflight_q && ((seg_q != SEG_BODY) || s_valid);

    // script decision taken once per finished frame
    always_comb begin
        go_frame = 1'b0; go_wait = 1'b0; go_fin = 1'b0;
        nxt_step = step_q; fin_code = RES_OK;
        case (step_q)
            STEP_IDENT:   if (ident_ok(word_q)) begin go_frame = 1'b1; nxt_step = STEP_STAT0; end
                          else begin go_fin = 1'b1; fin_code = RES_BAD_ID; end
            STEP_STAT0:   begin go_frame = 1'b1; nxt_step = STEP_REFRESH; end
            STEP_REFRESH: begin go_frame = 1'b1; nxt_step = STEP_WREN; end
            STEP_WREN:    begin go_frame = 1'b1; nxt_step = STEP_ERASE; end
            STEP_ERASE:   begin go_frame = 1'b1; nxt_step = STEP_POLL; end
            STEP_POLL:    if (word_q == STAT_ERASED) begin go_frame = 1'b1; nxt_step = STEP_IMAGE; end
                          else if (poll_q == PW'(MAX_POLLS - 1)) begin go_fin = 1'b1; fin_code = RES_ERASE_TO; end
                          else go_wait = 1'b1;
            STEP_IMAGE:   begin go_frame = 1'b1; nxt_step = STEP_WRDIS; end
            STEP_WRDIS:   begin go_frame = 1'b1; nxt_step = STEP_STATF; end
            default:      begin go_fin = 1'b1;
                              fin_code = ((word_q & STAT_CFG_BIT) != 32'h0) ? RES_OK : RES_NOT_CFG; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE; step_q <= STEP_IDENT; seg_q <= SEG_HEAD; res_q <= RES_OK;
            hidx_q <= '0; len_q <= '0; body_cnt_q <= '0; body_end_q <= 1'b0;
            inflight_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0;
            word_q <= '0; poll_q <= '0; gap_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    res_q <= RES_OK; done_q <= 1'b0;
                    if (img_len == '0) begin
                        done_q <= 1'b1; res_q <= RES_EMPTY;
                    end else begin
                        len_q <= img_len; step_q <= STEP_IDENT; body_cnt_q <= '0;
                        phase_q <= PH_FRAME; cs_q <= 1'b0; seg_q <= SEG_HEAD; hidx_q <= '0;
                    end
                end
                PH_FRAME: begin
                    if (sh_load) begin
                        inflight_q <= 1'b1;
                        if (seg_q == SEG_BODY) begin
                            body_cnt_q <= body_cnt_q + LEN_W'(1);
                            body_end_q <= s_last || (body_cnt_q == len_q - LEN_W'(1));
                        end
                    end
                    if (sh_done) begin
                        inflight_q <= 1'b0;
                        case (seg_q)
                            SEG_HEAD: if (hidx_q == 2'd3) begin
                                hidx_q <= '0;
                                if (step_q == STEP_IMAGE) seg_q <= SEG_BODY;
                                else if (step_reads(step_q)) seg_q <= SEG_TAIL;
                                else begin phase_q <= PH_GAP; cs_q <= 1'b1; gap_q <= '0; end
                            end else hidx_q <= hidx_q + 2'd1;
                            SEG_BODY: if (body_end_q) seg_q <= SEG_TAIL;
                            default: begin
                                word_q <= {word_q[23:0], sh_dout};
                                if (hidx_q == 2'd3) begin
                                    phase_q <= PH_GAP; cs_q <= 1'b1; gap_q <= '0;
                                end else hidx_q <= hidx_q + 2'd1;
                            end
                        endcase
                    end
                end
                PH_GAP: if (gap_q == GW'(GAP_CYC - 1)) phase_q <= PH_DECIDE;
                        else gap_q <= gap_q + GW'(1);
                PH_DECIDE: begin
                    if (go_frame) begin
                        step_q <= nxt_step; phase_q <= PH_FRAME; cs_q <= 1'b0;
                        seg_q <= SEG_HEAD; hidx_q <= '0;
                        if (nxt_step == STEP_POLL) poll_q <= '0;
                    end
                    if (go_wait) begin poll_q <= poll_q + PW'(1); phase_q <= PH_WAIT; end
                    if (go_fin) begin phase_q <= PH_IDLE; done_q <= 1'b1; res_q <= fin_code; end
                end
                default: if (wait_exp) begin
                    phase_q <= PH_FRAME; cs_q <= 1'b0; seg_q <= SEG_HEAD; hidx_q <= '0;
                end
            endcase
        end
    end

    cfgld_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .din(cur_byte), .miso(miso),
        .done(sh_done), .dout(sh_dout), .sclk(sclk), .mosi(mosi)
    );

    cfgld_tick_wait #(.COUNT(POLL_TICKS)) u_pause (
        .clk(clk), .rst(rst), .arm((phase_q == PH_DECIDE) && go_wait),
        .tick(ms_tick), .expired(wait_exp)
    );

    assign cs_n = cs_q;
    assign busy = (phase_q != PH_IDLE);
    assign done = done_q;
    assign err  = res_q;
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] img_len,
    input logic             busy,
    input logic             done,
    input logic [2:0]       err,
    input logic             cs_n,
    input logic             sclk,
    input logic             s_ready
);
    AST_EMPTY_ABORT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && img_len == '0) |=> (done && err == 3'd1 && cs_n && !busy)); // R1
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n); // R11
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk); // R11
    AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n); // R11
    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (!cs_n && busy)); // R9
    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R12
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(err))); // R12
endmodule

bind spi_cfg_loader cfgld_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len), .busy(busy),
    .done(done), .err(err), .cs_n(cs_n), .sclk(sclk), .s_ready(s_ready)
);

// File: tb/tb_spi_cfg_loader.sv
module tb_spi_cfg_loader;
    localparam int LEN_W = 16, HALF_DIV = 2, POLL_TICKS = 3, MAX_POLLS = 5;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [LEN_W-1:0] img_len = '0;
    logic [7:0] s_data = 8'h00;
    logic s_valid = 1'b0, s_last = 1'b0, s_ready, ms_tick = 1'b0;
    logic sclk, cs_n, mosi, miso = 1'b0, busy, done;
    logic [2:0] err;

    spi_cfg_loader #(.LEN_W(LEN_W), .HALF_DIV(HALF_DIV), .POLL_TICKS(POLL_TICKS),
                     .MAX_POLLS(MAX_POLLS)) dut (.*);

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- target model (bit-level SPI slave) ----------------
    logic [31:0] id_val, stat0_val, pollfail_val, final_val;
    int clr_after, poll_idx;
    bit seen_erase, seen_image;
    int rbits;
    byte unsigned fb[$];
    byte unsigned ops_q[$];
    int lens_q[$], ticks_q[$];
    byte unsigned img_rx[$];
    int pad_viol;
    logic [7:0] sh_in;

    function automatic logic [31:0] resp_word(byte unsigned op);
        if (op == 8'h07) return id_val;
        if (!seen_erase) return stat0_val;
        if (!seen_image) return (poll_idx < clr_after) ? pollfail_val : 32'h0001_0000;
        return final_val;
    endfunction

    initial forever begin
        @(negedge cs_n);
        rbits = 0; fb.delete(); miso = 1'b0;
    end
    initial forever begin
        @(posedge sclk);
        if (!cs_n) begin
            sh_in = {sh_in[6:0], mosi};
            rbits++;
            if (rbits % 8 == 0) fb.push_back(sh_in);
        end
    end
    initial forever begin
        @(negedge sclk);
        if (!cs_n) begin
            if (fb.size() > 0 && (fb[0] == 8'h07 || fb[0] == 8'h09) && rbits >= 32 && rbits < 64)
                miso = resp_word(fb[0])[63 - rbits];
            else miso = 1'b0;
        end
    end
    initial forever begin
        @(posedge cs_n);
        if (fb.size() > 0) begin
            ops_q.push_back(fb[0]);
            lens_q.push_back(fb.size());
            for (int i = 1; i < 4 && i < fb.size(); i++)
                if (fb[i] != ((fb[0] == 8'h41) ? 8'hFF : 8'h00)) pad_viol++;
            for (int i = 4; i < 8 && i < fb.size(); i++)
                if ((fb[0] == 8'h07 || fb[0] == 8'h09) && fb[i] != 8'h00) pad_viol++;
            if (fb[0] == 8'h41) begin
                for (int i = fb.size() - 4; i < fb.size(); i++) if (fb[i] != 8'h00) pad_viol++;
                for (int i = 4; i < fb.size() - 4; i++) img_rx.push_back(fb[i]);
                seen_image = 1'b1;
            end
            if (fb[0] == 8'h70) seen_erase = 1'b1;
            if (fb[0] == 8'h09 && seen_erase && !seen_image) poll_idx++;
        end
    end

    // ---------------- image stream source ----------------
    byte unsigned img_q[$];
    int sent, last_at, taken;
    bit stall, bubble;
    initial forever begin
        bit take;
        @(negedge clk);
        take = s_valid && s_ready;
        @(posedge clk); #1;
        if (take) begin void'(img_q.pop_front()); sent++; taken++; end
        bubble = stall ? !bubble : 1'b0;
        s_valid = (img_q.size() > 0) && !bubble;
        s_data  = (img_q.size() > 0) ? img_q[0] : 8'h00;
        s_last  = (sent == last_at);
    end

    // ---------------- tick source ----------------
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            ms_tick = (cyc % 8 == 0);
        end
    end

    // ---------------- per-clock reference invariants ----------------
    int inv_viol, hi_run, tick_acc;
    logic prev_cs = 1'b1;
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (cs_n && sclk) inv_viol++;              // R11
            if (!busy && !cs_n) inv_viol++;            // R12
            if (s_ready && (cs_n || !busy)) inv_viol++; // R9
            if (prev_cs && !cs_n) begin
                if (hi_run < 2 * HALF_DIV) inv_viol++; // R11
                ticks_q.push_back(tick_acc);
            end
            if (!prev_cs && cs_n) begin hi_run = 0; tick_acc = 0; end
            if (cs_n) begin hi_run++; if (ms_tick) tick_acc++; end
            prev_cs = cs_n;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "run did not finish", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- one configuration run ----------------
    task automatic run_case(string name, logic [31:0] idv, logic [31:0] st0, logic [31:0] pfail,
                            int clr, logic [31:0] fin, int qbytes, int len, int lastidx,
                            bit stl, bit poke, logic [2:0] exp_err, int exp_body);
        byte unsigned exp_ops[$];
        byte unsigned gen[$];
        bit ok;
        int cyc;
        id_val = idv; stat0_val = st0; pollfail_val = pfail; final_val = fin; clr_after = clr;
        poll_idx = 0; seen_erase = 0; seen_image = 0;
        ops_q.delete(); lens_q.delete(); ticks_q.delete(); img_rx.delete();
        pad_viol = 0; inv_viol = 0; taken = 0; sent = 0; last_at = lastidx; stall = stl;
        img_q.delete();
        for (int i = 0; i < qbytes; i++) begin
            gen.push_back(8'((i * 37 + 11) ^ (len * 5)));
            img_q.push_back(gen[i]);
        end
        if (exp_err != 3'd1) exp_ops.push_back(8'h07);
        if (exp_err != 3'd1 && exp_err != 3'd2) begin
            exp_ops.push_back(8'h09); exp_ops.push_back(8'h71);
            exp_ops.push_back(8'h4A); exp_ops.push_back(8'h70);
            if (exp_err == 3'd3) for (int i = 0; i < MAX_POLLS; i++) exp_ops.push_back(8'h09);
            else begin
                for (int i = 0; i <= clr; i++) exp_ops.push_back(8'h09);
                exp_ops.push_back(8'h41); exp_ops.push_back(8'h4F); exp_ops.push_back(8'h09);
            end
        end
        img_len = LEN_W'(len);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        if (exp_err == 3'd1)
            check(done && err == 3'd1 && !busy, "R1", {name, " empty abort next cycle"}, {done, err}, 4'b1001);
        else
            check(busy && !done, "R12", {name, " busy after start"}, {busy, done}, 2'b10);
        cyc = 0;
        while (!(done && !busy) && cyc < 20000) begin
            if (poke && cyc == 200) begin
                img_len = '0; start = 1'b1;
                @(negedge clk); start = 1'b0; img_len = LEN_W'(len);
            end else @(negedge clk);
            cyc++;
        end
        repeat (3) @(negedge clk);
        check(err == exp_err && done, exp_err == 3'd2 ? "R3" : exp_err == 3'd3 ? "R6" :
              exp_err == 3'd4 ? "R10" : exp_err == 3'd1 ? "R1" : "R10",
              {name, " result code"}, err, exp_err);
        ok = (ops_q.size() == exp_ops.size());
        for (int i = 0; ok && i < exp_ops.size(); i++) if (ops_q[i] != exp_ops[i]) ok = 0;
        check(ok, "R4", {name, " frame opcode sequence (count)"}, ops_q.size(), exp_ops.size());
        ok = 1;
        for (int i = 0; i < lens_q.size() && i < ops_q.size(); i++) begin
            int el = (ops_q[i] == 8'h07 || ops_q[i] == 8'h09) ? 8 :
                     (ops_q[i] == 8'h41) ? 8 + exp_body : 4;
            if (lens_q[i] != el) ok = 0;
        end
        check(ok, "R7", {name, " frame lengths"}, ok, 1);
        check(pad_viol == 0, "R2", {name, " pad bytes"}, pad_viol, 0);
        check(inv_viol == 0, "R11", {name, " mode-0 and chip-select invariants"}, inv_viol, 0);
        if (exp_err == 3'd0 || exp_err == 3'd4) begin
            ok = (img_rx.size() == exp_body);
            for (int i = 0; ok && i < exp_body; i++) if (img_rx[i] != gen[i]) ok = 0;
            check(ok, "R8", {name, " image body bytes"}, img_rx.size(), exp_body);
            check(taken == exp_body, "R9", {name, " stream handshakes"}, taken, exp_body);
        end else begin
            check(taken == 0 && img_rx.size() == 0, "R6", {name, " no image sent"}, taken, 0);
        end
        ok = 1;
        for (int i = 6; i < ops_q.size() && i < ticks_q.size(); i++)
            if (ops_q[i] == 8'h09 && ops_q[i-1] == 8'h09 &&
                (ticks_q[i] < POLL_TICKS || ticks_q[i] > POLL_TICKS + 1)) ok = 0;
        check(ok, "R5", {name, " tick pause between polls"}, ok, 1);
        repeat (4) @(negedge clk);
        check(done && err == exp_err, "R12", {name, " result held after run"}, err, exp_err);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && cs_n && !sclk && !s_ready && err == 3'd0, "R12",
              "reset state", {busy, done, cs_n, sclk, s_ready, err}, 8'b00100000);
        // R1: empty image
        run_case("empty", 32'hC2088080, 0, 0, 0, 0, 0, 0, -1, 0, 0, 3'd1, 0);
        // R3: one-bit-off identity is rejected
        run_case("badid", 32'hC2088081, 0, 0, 0, 0, 4, 4, -1, 0, 0, 3'd2, 0);
        // R2 R4 R5 R7 R10 R12: full success, mid-run start ignored
        run_case("ok_a", 32'hC2088080, 32'h0, 32'h0, 2, 32'h0001_4000, 5, 5, 4, 0, 1, 3'd0, 5);
        // R5 exact compare, R8 early last flag with stalls, R10 not configured
        run_case("last", 32'hC2048080, 32'h1, 32'h0001_0001, 1, 32'h0001_0000, 6, 6, 2, 1, 0, 3'd4, 3);
        // R8: body ends at length with more bytes offered
        run_case("len", 32'hC2048080, 32'h0, 32'h0, 0, 32'hFFFF_FFFF, 6, 4, -1, 0, 0, 3'd0, 4);
        // R6: never cleared
        run_case("tmo", 32'hC2088080, 32'h0, 32'h0, 99, 32'h0, 3, 3, -1, 0, 0, 3'd3, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule